// File: doc/BRIEF.md
# Global-Clock Flip-Flop Emulator

This block stands in for an edge-triggered register whose clock must not be used as a real clock. A single fast global clock drives every storage element. The register's own clock arrives as an ordinary data input. Each global cycle, the block compares that input with the value it held one cycle earlier, and so recognises the active edge as a level change between two samples.

When an active edge is seen, the output shows the data value captured at the previous global edge. In every other cycle it shows the output value captured at that same global edge. The output is a combinational function of the current inputs and a few history registers. An asynchronous reset, or per-bit set and clear inputs, therefore act on the output without delay.

Parameters choose the width, the active clock edge, the control variant (none, asynchronous reset, or set/clear) and the active level of each control. A design that uses several clocks can be rewritten so that every register is one of these emulators under one common clock.

Top module: `emu_ff_gclk`

## Requirements
- R1: Every history register updates on the rising edge of `gclk` only and has a power-up value. The clock history powers up at 1 when `RISING`=1 and at 0 when `RISING`=0. The data history and output history both power up at `INIT`, so `q_out` equals `INIT` until the first active edge.
- R2: With `RISING`=1, an active edge is a `lclk` sample of 1 whose previous sample was 0. With `RISING`=0, it is a sample of 0 whose previous sample was 1. A transition in the opposite direction leaves `q_out` unchanged.
- R3: In a global cycle that holds an active edge, `q_out` equals the value `d_in` had at the preceding `gclk` rising edge. A `d_in` change made in the same cycle as the clock change is not captured.
- R4: In a cycle without an active edge, and with no control asserted, `q_out` equals the value `q_out` had at the preceding `gclk` rising edge.
- R5: With `MODE`=`EMU_ARST`, `q_out` equals `RST_VALUE` in the same cycle that the reset input reaches its active level. There is no wait for `gclk`.
- R6: After the reset input is released, reset stays in force until the next `gclk` rising edge. An active `lclk` edge that falls inside the stretched interval is lost.
- R7: With `RST_HIGH`=0, the reset is active at logic 0. The effective reset is asserted when the current reset input or its previous sample is 0.
- R8: With `MODE`=`EMU_SETCLR`, every bit whose set input is at its active level reads 1. `SET_HIGH`=0 means a set bit is active at 0. The forced value enters the output history, so it persists after the set is released until the next active edge.
- R9: In set/clear mode, every bit whose clear input is at its active level reads 0, even when its set bit is also active. With `CLR_HIGH`=1, clear is active at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock; every register in the block uses its rising edge |
| lclk | input | 1 | Emulated register clock, handled as data |
| d_in | input | WIDTH | Data to be captured on an active edge |
| rst_in | input | 1 | Asynchronous reset of the emulated register (used when MODE=EMU_ARST) |
| set_in | input | WIDTH | Per-bit asynchronous set (used when MODE=EMU_SETCLR) |
| clr_in | input | WIDTH | Per-bit asynchronous clear (used when MODE=EMU_SETCLR) |
| q_out | output | WIDTH | Emulated register output |

## Verification
The bench changes data in the same global cycle as a clock edge. A design that sampled current data there instead of the previous sample would show the new value one cycle early. It releases reset and then raises the local clock at once. A design without the one-cycle reset stretch would capture data that should have been lost. It also checks that the reset value holds afterwards.

Falling transitions are applied to a rising-edge instance and the reverse. An edge detector built on the wrong comparison would load data on them. Set and clear are applied to overlapping bits, and their effect is checked after release. An output history that stored only the edge-selected value, or an ordering where set beats clear, gives a different byte.

// File: rtl/emu_ff_pkg.sv
`timescale 1ns/1ps
package emu_ff_pkg;

  typedef enum logic [1:0] {
    EMU_PLAIN  = 2'd0,
    EMU_ARST   = 2'd1,
    EMU_SETCLR = 2'd2
  } emu_mode_e;

  // Active edge between two consecutive samples of the emulated clock.
  function automatic logic edge_seen(input logic prev, input logic cur, input logic rising);
    return rising ? (!prev && cur) : (prev && !cur);
  endfunction

  // Converts a control level into an active-high flag.
  function automatic logic level_on(input logic v, input logic high);
    return high ? v : !v;
  endfunction

  // Reset is in force if either the current or the previous sample is active.
  function automatic logic rst_merge(input logic cur, input logic prev, input logic high);
    return high ? (cur | prev) : !(cur & prev);
  endfunction

endpackage

// File: rtl/emu_clk_edge.sv
`timescale 1ns/1ps
module emu_clk_edge
  import emu_ff_pkg::*;
#(
  parameter bit RISING = 1'b1
) (
  input  logic gclk,
  input  logic lclk,
  output logic edge_hit
);

  // Power-up value equals the post-edge level, so no edge is inferred at start-up.
  logic lclk_prev = RISING;

  always_ff @(posedge gclk) begin
    lclk_prev <= lclk;
  end

  assign edge_hit = edge_seen(lclk_prev, lclk, RISING);

endmodule

// File: rtl/emu_hist.sv
`timescale 1ns/1ps
module emu_hist #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] INIT  = '0
) (
  input  logic             gclk,
  input  logic [WIDTH-1:0] d_now,
  input  logic [WIDTH-1:0] q_now,
  output logic [WIDTH-1:0] d_prev,
  output logic [WIDTH-1:0] q_prev
);

  // Both histories start at the register's initial value.
  logic [WIDTH-1:0] d_hold = INIT;
  logic [WIDTH-1:0] q_hold = INIT;

  always_ff @(posedge gclk) begin
    d_hold <= d_now;
    q_hold <= q_now;
  end

  assign d_prev = d_hold;
  assign q_prev = q_hold;

endmodule

// File: rtl/emu_out_stage.sv
`timescale 1ns/1ps
module emu_out_stage
  import emu_ff_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter emu_mode_e        MODE      = EMU_ARST,
  parameter bit               RST_HIGH  = 1'b1,
  parameter logic [WIDTH-1:0] RST_VALUE = '0,
  parameter bit               SET_HIGH  = 1'b1,
  parameter bit               CLR_HIGH  = 1'b1
) (
  input  logic             gclk,
  input  logic             edge_hit,
  input  logic [WIDTH-1:0] d_prev,
  input  logic [WIDTH-1:0] q_prev,
  input  logic             rst_in,
  input  logic [WIDTH-1:0] set_in,
  input  logic [WIDTH-1:0] clr_in,
  output logic             rst_on,
  output logic [WIDTH-1:0] q_out
);

  localparam bit HAS_RST = (MODE == EMU_ARST);
  localparam bit HAS_SC  = (MODE == EMU_SETCLR);

  logic [WIDTH-1:0] sel_val;
  logic [WIDTH-1:0] set_act;
  logic [WIDTH-1:0] clr_act;
  logic [WIDTH-1:0] set_m;
  logic [WIDTH-1:0] clr_m;
  logic             rst_prev;

  assign sel_val = edge_hit ? d_prev : q_prev;

  // Reset history exists only in reset mode; elsewhere it sits at the idle level.
  generate
    if (HAS_RST) begin : g_rst_hist
      logic rst_q = !RST_HIGH;
      always_ff @(posedge gclk) begin
        rst_q <= rst_in;
      end
      assign rst_prev = rst_q;
    end else begin : g_rst_none
      assign rst_prev = !RST_HIGH;
    end
  endgenerate

  assign rst_on = HAS_RST && rst_merge(rst_in, rst_prev, RST_HIGH);

  // Per-bit polarity conversion of set and clear.
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign set_act[b] = level_on(set_in[b], SET_HIGH);
      assign clr_act[b] = level_on(clr_in[b], CLR_HIGH);
    end
  endgenerate

  assign set_m = HAS_SC ? set_act : '0;
  assign clr_m = HAS_SC ? clr_act : '0;

  // Clear is applied last, so it wins over set.
  assign q_out = rst_on ? RST_VALUE : ((sel_val | set_m) & ~clr_m);

endmodule

// File: rtl/emu_ff_gclk.sv
`timescale 1ns/1ps
module emu_ff_gclk
  import emu_ff_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter bit               RISING    = 1'b1,
  parameter emu_mode_e        MODE      = EMU_ARST,
  parameter bit               RST_HIGH  = 1'b1,
  parameter logic [WIDTH-1:0] RST_VALUE = '0,
  parameter bit               SET_HIGH  = 1'b1,
  parameter bit               CLR_HIGH  = 1'b1,
  parameter logic [WIDTH-1:0] INIT      = '0
) (
  input  logic             gclk,
  input  logic             lclk,
  input  logic [WIDTH-1:0] d_in,
  input  logic             rst_in,
  input  logic [WIDTH-1:0] set_in,
  input  logic [WIDTH-1:0] clr_in,
  output logic [WIDTH-1:0] q_out
);

  // Named internal events, visible to the bound checker.
  logic             edge_hit;
  logic             rst_on;
  logic [WIDTH-1:0] d_prev;
  logic [WIDTH-1:0] q_prev;

  emu_clk_edge #(
    .RISING (RISING)
  ) u_edge (
    .gclk     (gclk),
    .lclk     (lclk),
    .edge_hit (edge_hit)
  );

  emu_hist #(
    .WIDTH (WIDTH),
    .INIT  (INIT)
  ) u_hist (
    .gclk   (gclk),
    .d_now  (d_in),
    .q_now  (q_out),
    .d_prev (d_prev),
    .q_prev (q_prev)
  );

  emu_out_stage #(
    .WIDTH     (WIDTH),
    .MODE      (MODE),
    .RST_HIGH  (RST_HIGH),
    .RST_VALUE (RST_VALUE),
    .SET_HIGH  (SET_HIGH),
    .CLR_HIGH  (CLR_HIGH)
  ) u_out (
    .gclk     (gclk),
    .edge_hit (edge_hit),
    .d_prev   (d_prev),
    .q_prev   (q_prev),
    .rst_in   (rst_in),
    .set_in   (set_in),
    .clr_in   (clr_in),
    .rst_on   (rst_on),
    .q_out    (q_out)
  );

endmodule

// File: rtl/emu_ff_gclk_chk.sv
`timescale 1ns/1ps
module emu_ff_gclk_chk
  import emu_ff_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter bit               RISING    = 1'b1,
  parameter emu_mode_e        MODE      = EMU_ARST,
  parameter bit               RST_HIGH  = 1'b1,
  parameter logic [WIDTH-1:0] RST_VALUE = '0,
  parameter bit               SET_HIGH  = 1'b1,
  parameter bit               CLR_HIGH  = 1'b1
) (
  input logic             gclk,
  input logic             lclk,
  input logic [WIDTH-1:0] d_in,
  input logic             rst_in,
  input logic [WIDTH-1:0] set_in,
  input logic [WIDTH-1:0] clr_in,
  input logic [WIDTH-1:0] q_out,
  input logic             edge_hit,
  input logic             rst_on
);

  // Properties are enabled once the history holds real samples.
  logic [1:0] warm = 2'd0;
  always_ff @(posedge gclk) begin
    if (warm != 2'd2) warm <= warm + 2'd1;
  end

  logic armed;
  logic rst_lvl;
  logic [WIDTH-1:0] s_on;
  logic [WIDTH-1:0] c_on;

  assign armed   = (warm == 2'd2);
  assign rst_lvl = RST_HIGH ? rst_in : !rst_in;
  assign s_on    = SET_HIGH ? set_in : ~set_in;
  assign c_on    = CLR_HIGH ? clr_in : ~clr_in;

  p_edge_dir_r2: assert property (@(posedge gclk) disable iff (!armed)
    edge_hit |-> (lclk == RISING) && ($past(lclk) != RISING));

  p_edge_load_r3: assert property (@(posedge gclk) disable iff (!armed)
    (edge_hit && !rst_on && MODE != EMU_SETCLR) |-> (q_out == $past(d_in)));

  p_hold_r4: assert property (@(posedge gclk) disable iff (!armed)
    (!edge_hit && !rst_on && MODE != EMU_SETCLR) |-> (q_out == $past(q_out)));

  p_rst_force_r5: assert property (@(posedge gclk) disable iff (!armed)
    rst_on |-> (q_out == RST_VALUE));

  p_rst_stretch_r6: assert property (@(posedge gclk) disable iff (!armed)
    (MODE == EMU_ARST && $fell(rst_lvl)) |-> rst_on);

  p_rst_level_r7: assert property (@(posedge gclk) disable iff (!armed)
    (MODE == EMU_ARST && rst_lvl) |-> rst_on);

  p_set_bits_r8: assert property (@(posedge gclk) disable iff (!armed)
    (MODE == EMU_SETCLR) |-> ((q_out & s_on & ~c_on) == (s_on & ~c_on)));

  p_clr_wins_r9: assert property (@(posedge gclk) disable iff (!armed)
    (MODE == EMU_SETCLR) |-> ((q_out & c_on) == '0));

endmodule

bind emu_ff_gclk emu_ff_gclk_chk #(
  .WIDTH     (WIDTH),
  .RISING    (RISING),
  .MODE      (MODE),
  .RST_HIGH  (RST_HIGH),
  .RST_VALUE (RST_VALUE),
  .SET_HIGH  (SET_HIGH),
  .CLR_HIGH  (CLR_HIGH)
) u_chk (
  .gclk     (gclk),
  .lclk     (lclk),
  .d_in     (d_in),
  .rst_in   (rst_in),
  .set_in   (set_in),
  .clr_in   (clr_in),
  .q_out    (q_out),
  .edge_hit (edge_hit),
  .rst_on   (rst_on)
);

// File: tb/emu_ff_gclk_tb.sv
`timescale 1ns/1ps
module emu_ff_gclk_tb;
  import emu_ff_pkg::*;

  logic       gclk  = 1'b0;
  logic       lclk  = 1'b0;
  logic [7:0] d     = 8'h00;
  logic       rst_h = 1'b0;
  logic       rst_n = 1'b1;
  logic [7:0] set_n = 8'hFF;
  logic [7:0] clr   = 8'h00;
  logic [7:0] q_dut, q_nr, q_sc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 gclk = ~gclk;

  // Rising edge, active-high reset to A5, initial 3C.
  emu_ff_gclk #(.WIDTH(8), .RISING(1'b1), .MODE(EMU_ARST), .RST_HIGH(1'b1),
                .RST_VALUE(8'hA5), .SET_HIGH(1'b1), .CLR_HIGH(1'b1), .INIT(8'h3C))
    u_dut (.gclk(gclk), .lclk(lclk), .d_in(d), .rst_in(rst_h),
           .set_in(8'h00), .clr_in(8'h00), .q_out(q_dut));

  // Rising edge, active-low reset to 00.
  emu_ff_gclk #(.WIDTH(8), .RISING(1'b1), .MODE(EMU_ARST), .RST_HIGH(1'b0),
                .RST_VALUE(8'h00), .SET_HIGH(1'b1), .CLR_HIGH(1'b1), .INIT(8'h3C))
    u_nr (.gclk(gclk), .lclk(lclk), .d_in(d), .rst_in(rst_n),
          .set_in(8'h00), .clr_in(8'h00), .q_out(q_nr));

  // Falling edge, active-low set, active-high clear, initial 0F.
  emu_ff_gclk #(.WIDTH(8), .RISING(1'b0), .MODE(EMU_SETCLR), .RST_HIGH(1'b1),
                .RST_VALUE(8'h00), .SET_HIGH(1'b0), .CLR_HIGH(1'b1), .INIT(8'h0F))
    u_sc (.gclk(gclk), .lclk(lclk), .d_in(d), .rst_in(1'b0),
          .set_in(set_n), .clr_in(clr), .q_out(q_sc));

  // Row layout {lclk, rst_h, d, expected q_dut}; expected values follow R2..R6.
  localparam logic [17:0] VEC [15] = '{
    {1'b0, 1'b0, 8'h11, 8'h3C},
    {1'b1, 1'b0, 8'h22, 8'h11},
    {1'b1, 1'b0, 8'h33, 8'h11},
    {1'b0, 1'b0, 8'h44, 8'h11},
    {1'b0, 1'b0, 8'h55, 8'h11},
    {1'b1, 1'b0, 8'h66, 8'h55},
    {1'b1, 1'b1, 8'h66, 8'hA5},
    {1'b0, 1'b0, 8'h77, 8'hA5},
    {1'b0, 1'b0, 8'h77, 8'hA5},
    {1'b1, 1'b0, 8'h88, 8'h77},
    {1'b0, 1'b1, 8'h99, 8'hA5},
    {1'b1, 1'b0, 8'hAA, 8'hA5},
    {1'b1, 1'b0, 8'hBB, 8'hA5},
    {1'b0, 1'b0, 8'hBB, 8'hA5},
    {1'b1, 1'b0, 8'hCC, 8'hBB}
  };

  function automatic string row_tag(input int i);
    case (i)
      1, 5, 9, 14: return "R3";
      3:           return "R2";
      6, 10:       return "R5";
      7, 8, 11, 12: return "R6";
      default:     return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // Drive on the falling global edge, sample 2 ns later, before the next rising edge.
  task automatic drive(input logic l, input logic [7:0] dv, input logic rh,
                       input logic rn, input logic [7:0] sn, input logic [7:0] cl);
    @(negedge gclk);
    lclk = l; d = dv; rst_h = rh; rst_n = rn; set_n = sn; clr = cl;
    #2;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #1;
    chk("R1 initial q (rising)", q_dut, 8'h3C);
    chk("R1 initial q (falling)", q_sc, 8'h0F);

    for (int i = 0; i < 15; i++) begin
      drive(VEC[i][17], VEC[i][15:8], VEC[i][16], 1'b1, 8'hFF, 8'h00);
      chk(row_tag(i), q_dut, VEC[i][7:0]);
    end

    // R7: active-low reset, stretched by one cycle, then a clean capture.
    drive(1'b1, 8'hCC, 1'b0, 1'b0, 8'hFF, 8'h00);
    chk("R7 low reset forces", q_nr, 8'h00);
    drive(1'b0, 8'hCC, 1'b0, 1'b1, 8'hFF, 8'h00);
    chk("R7 low reset stretch", q_nr, 8'h00);
    chk("R2 falling edge loads", q_sc, 8'hCC);
    drive(1'b1, 8'hDD, 1'b0, 1'b1, 8'hFF, 8'h00);
    chk("R7 capture after release", q_nr, 8'hCC);
    chk("R2 rising ignored by falling instance", q_sc, 8'hCC);

    // R8/R9 on the falling-edge set/clear instance.
    drive(1'b1, 8'h5A, 1'b0, 1'b1, 8'hFF, 8'h00);
    drive(1'b0, 8'h00, 1'b0, 1'b1, 8'hFF, 8'h00);
    chk("R3 falling capture", q_sc, 8'h5A);
    drive(1'b0, 8'h00, 1'b0, 1'b1, 8'h7E, 8'h00);
    chk("R8 set bits 7 and 0", q_sc, 8'hDB);
    drive(1'b0, 8'h00, 1'b0, 1'b1, 8'hFF, 8'h0A);
    chk("R8 set persists, clear applied", q_sc, 8'hD1);
    drive(1'b0, 8'h00, 1'b0, 1'b1, 8'hF0, 8'h03);
    chk("R9 clear wins over set", q_sc, 8'hDC);
    drive(1'b0, 8'h00, 1'b0, 1'b1, 8'hFF, 8'h00);
    chk("R8 hold after release", q_sc, 8'hDC);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule